// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block sits beside the command arbiter of a DDR2-class memory controller and decides when the memory must be refreshed. It runs a down-counter, in controller clock cycles, that fires once per average refresh interval. Each time the counter fires, one refresh becomes owed. When the hot flag is high, the next interval is half as long. The block asks the arbiter for a refresh whenever one is owed. After the arbiter grants it, the block holds off every other command for the refresh recovery time.

The block also runs the self-refresh handshake. It accepts entry and exit requests and keeps the clock-enable level stable for a minimum number of cycles between them. After exit it raises two separate recovery windows. The first is time-based and applies to non-read commands. The second is a fixed cycle count and applies to reads. All cycle counts are derived at elaboration from a clock-period parameter: each time value is divided by the clock period and rounded up.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and in the first sample after reset, ref_req_o, ref_urgent_o, block_cmd_o, block_rd_o and in_sr_o are all 0.
- R2: The first owed refresh appears on ref_req_o exactly COOL cycles after reset is released. COOL = ceil(7.8 us / clock period), which is 2080 at the default 3750 ps. Each later increment of the owed count comes one interval after the previous one. The interval is COOL when hot_i was 0 at the clock edge of the previous increment, and HOT = ceil(3.9 us / clock period) = 1040 when hot_i was 1. A change of hot_i never shortens the interval in progress.
- R3: A grant is accepted when ref_grant_i is 1 in a cycle where ref_req_o is 1. An accepted grant removes one owed refresh and holds block_cmd_o at 1 for exactly TRFC = ceil(195 ns / clock period) = 52 cycles, starting with the cycle after the grant. During those cycles ref_req_o is 0. A grant given while ref_req_o is 0 has no effect, and block_cmd_o stays 0.
- R4: The owed count saturates at 8. ref_urgent_o is 1 exactly while 8 refreshes are owed. Intervals that expire at that level are dropped, so exactly 8 grants clear the count even after further intervals have passed.
- R5: ref_req_o is 1 exactly when at least one refresh is owed and block_cmd_o is 0.
- R6: A pulse on sr_enter_i enters self-refresh only under all of these conditions: the block is awake, no refresh or exit recovery is running, the clock-enable hold time has passed, and no grant is accepted in the same cycle. On entry, in_sr_o goes to 1 in the next cycle and the owed count is cleared. While in self-refresh, block_cmd_o and block_rd_o are 1, ref_req_o is 0, and the interval counter is held.
- R7: An exit request is accepted no sooner than CKE_MIN_CYC = 3 clock edges after the entry edge. Entry after an exit obeys the same spacing. An exit request held high from entry onward therefore clears in_sr_o after the third edge.
- R8: After an accepted exit, block_cmd_o stays 1 for XSNR = ceil((195 ns + 10 ns) / clock period) = 55 cycles. block_rd_o stays 1 for 200 cycles. block_rd_o is 1 whenever block_cmd_o is 1.
- R9: At the exit edge the interval counter restarts, using the hot_i value sampled at that edge. The first owed refresh after exit therefore appears HOT or COOL cycles after the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Case temperature above the normal range; selects the halved interval |
| ref_grant_i | input | 1 | Arbiter issues the requested refresh this cycle |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| ref_req_o | output | 1 | At least one refresh is owed and may be issued now |
| ref_urgent_o | output | 1 | The owed count has reached its limit of 8 |
| block_cmd_o | output | 1 | No activate, refresh or other non-read command may be issued |
| block_rd_o | output | 1 | No read command may be issued |
| in_sr_o | output | 1 | Memory is in self-refresh |

## Verification
The assertions check the following on every cycle:
- an accepted grant raises the command block and drops the request in the next cycle;
- self-refresh forces both blocks and silences the request;
- entry happens only on a request;
- self-refresh lasts at least the clock-enable hold time;
- the read block covers the command block;
- leaving self-refresh starts with an empty owed count.

Some properties can only be shown by the bench scenarios, because they depend on exact cycle counts. These are the interval lengths under each sequence of hot-flag changes, the exact lengths of the three recovery windows, the saturation at 8 owed refreshes drained by exactly 8 grants, and the restart of the interval from the temperature seen at exit.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic {
        SR_AWAKE   = 1'b0,
        SR_ASLEEP  = 1'b1
    } sr_state_e;

    // Integer division rounded up, used to turn picosecond limits into cycles.
    function automatic int ceil_div(input longint num, input longint den);
        return int'((num + den - 1) / den);
    endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int COOL_CYC = 2080,
    parameter int HOT_CYC  = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic hot_i,
    output logic expire_o
);
    localparam int MAX_CYC = (COOL_CYC > HOT_CYC) ? COOL_CYC : HOT_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t        st_d, st_q;
    logic [CW-1:0] reload;

    always_comb begin
        reload   = hot_i ? CW'(HOT_CYC - 1) : CW'(COOL_CYC - 1);
        st_d     = st_q;
        expire_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = reload;
        end else if (run_i) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(COOL_CYC - 1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic take_i,
    input  logic clear_i,
    output logic owed_o,
    output logic full_o
);
    localparam int DW = $clog2(DEBT_MAX + 1);

    typedef struct packed {
        logic [DW-1:0] debt;
    } debt_t;

    debt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.debt = '0;
        end else if (add_i && !take_i) begin
            if (st_q.debt != DW'(DEBT_MAX)) begin
                st_d.debt = st_q.debt + 1'b1;
            end
        end else if (take_i && !add_i) begin
            if (st_q.debt != '0) begin
                st_d.debt = st_q.debt - 1'b1;
            end
        end
        owed_o = (st_q.debt != '0);
        full_o = (st_q.debt == DW'(DEBT_MAX));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.debt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/recov_timer.sv
module recov_timer #(
    parameter int LOAD = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int LV = (LOAD < 1) ? 1 : LOAD;
    localparam int TW = $clog2(LV + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } rec_t;

    rec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = TW'(LOAD);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        busy_o = (st_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_PS         = 3750,
    parameter int REFI_COOL_PS   = 7_800_000,
    parameter int REFI_HOT_PS    = 3_900_000,
    parameter int TRFC_PS        = 195_000,
    parameter int XSNR_MARGIN_PS = 10_000,
    parameter int XSRD_CYC       = 200,
    parameter int CKE_MIN_CYC    = 3,
    parameter int DEBT_MAX       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic ref_grant_i,
    input  logic sr_enter_i,
    input  logic sr_exit_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic block_cmd_o,
    output logic block_rd_o,
    output logic in_sr_o
);
    localparam int COOL_CYC = ceil_div(REFI_COOL_PS, CLK_PS);
    localparam int HOT_CYC  = ceil_div(REFI_HOT_PS, CLK_PS);
    localparam int TRFC_CYC = ceil_div(TRFC_PS, CLK_PS);
    localparam int XSNR_CYC = ceil_div(longint'(TRFC_PS) + XSNR_MARGIN_PS, CLK_PS);
    localparam int CKE_LOAD = (CKE_MIN_CYC > 1) ? CKE_MIN_CYC - 1 : 1;

    typedef struct packed {
        sr_state_e st;
    } top_t;

    top_t st_d, st_q;

    logic awake;
    logic expire;
    logic owed, full;
    logic trfc_busy, xsnr_busy, xsrd_busy, cke_busy;
    logic take, enter_ok, exit_ok;

    always_comb begin
        st_d     = st_q;
        awake    = (st_q.st == SR_AWAKE);
        ref_req_o = awake && owed && !trfc_busy && !xsnr_busy;
        take     = ref_req_o && ref_grant_i;
        enter_ok = awake && sr_enter_i && !trfc_busy && !xsnr_busy
                   && !cke_busy && !take;
        exit_ok  = !awake && sr_exit_i && !cke_busy;
        if (enter_ok) begin
            st_d.st = SR_ASLEEP;
        end else if (exit_ok) begin
            st_d.st = SR_AWAKE;
        end
        block_cmd_o  = !awake || trfc_busy || xsnr_busy;
        block_rd_o   = block_cmd_o || xsrd_busy;
        ref_urgent_o = full;
        in_sr_o      = !awake;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st <= SR_AWAKE;
        end else begin
            st_q <= st_d;
        end
    end

    refi_timer #(
        .COOL_CYC (COOL_CYC),
        .HOT_CYC  (HOT_CYC)
    ) u_refi (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (awake),
        .restart_i (exit_ok),
        .hot_i     (hot_i),
        .expire_o  (expire)
    );

    refresh_debt #(
        .DEBT_MAX (DEBT_MAX)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_i   (expire),
        .take_i  (take),
        .clear_i (enter_ok),
        .owed_o  (owed),
        .full_o  (full)
    );

    recov_timer #(.LOAD(TRFC_CYC)) u_trfc (
        .clk (clk), .rst_n (rst_n), .start_i (take), .busy_o (trfc_busy)
    );

    recov_timer #(.LOAD(XSNR_CYC)) u_xsnr (
        .clk (clk), .rst_n (rst_n), .start_i (exit_ok), .busy_o (xsnr_busy)
    );

    recov_timer #(.LOAD(XSRD_CYC)) u_xsrd (
        .clk (clk), .rst_n (rst_n), .start_i (exit_ok), .busy_o (xsrd_busy)
    );

    recov_timer #(.LOAD(CKE_LOAD)) u_cke (
        .clk (clk), .rst_n (rst_n), .start_i (enter_ok || exit_ok), .busy_o (cke_busy)
    );

endmodule

// File: rtl/dram_ref_sched_chk.sv
module dram_ref_sched_chk #(
    parameter int CKE_MIN_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic hot_i,
    input logic ref_grant_i,
    input logic sr_enter_i,
    input logic sr_exit_i,
    input logic ref_req_o,
    input logic ref_urgent_o,
    input logic block_cmd_o,
    input logic block_rd_o,
    input logic in_sr_o
);
    localparam int AW = $clog2(CKE_MIN_CYC + 2);

    logic [AW-1:0] sr_age;

    // Cycles spent in self-refresh, saturating just above the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_age <= '0;
        end else if (in_sr_o) begin
            if (sr_age < AW'(CKE_MIN_CYC + 1)) begin
                sr_age <= sr_age + 1'b1;
            end
        end else begin
            sr_age <= '0;
        end
    end

    p_grant_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && ref_grant_i) |=> (block_cmd_o && !ref_req_o));

    p_urgent_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent_o && !block_cmd_o) |-> ref_req_o);

    p_asleep_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_sr_o |-> (block_cmd_o && block_rd_o && !ref_req_o));

    p_entry_on_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sr_o) |-> $past(sr_enter_i));

    p_exit_clears_debt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sr_o) |-> !ref_urgent_o);

    p_cke_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sr_o) |-> (sr_age >= AW'(CKE_MIN_CYC)));

    p_exit_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sr_o) |-> (block_cmd_o && block_rd_o));

    p_rd_covers_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        block_cmd_o |-> block_rd_o);

endmodule

bind dram_refresh_sched dram_ref_sched_chk #(.CKE_MIN_CYC(CKE_MIN_CYC)) u_chk (.*);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;

    localparam int CLK_NS   = 10;
    localparam int PER_PS   = 3750;
    localparam int COOL     = (7_800_000 + PER_PS - 1) / PER_PS;
    localparam int HOT      = (3_900_000 + PER_PS - 1) / PER_PS;
    localparam int TRFC     = (195_000 + PER_PS - 1) / PER_PS;
    localparam int XSNR     = (205_000 + PER_PS - 1) / PER_PS;
    localparam int XSRD     = 200;
    localparam int NROWS    = 6;

    // Row i: hot level applied just after request i, and expected gap to request i+1
    // (gap follows the hot level of the previous row, since the reload already happened).
    localparam bit TBL_HOT [NROWS] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int TBL_GAP [NROWS] = '{COOL, HOT, HOT, COOL, COOL, HOT};

    logic clk = 1'b0;
    logic rst_n, hot_i, ref_grant_i, sr_enter_i, sr_exit_i;
    logic ref_req_o, ref_urgent_o, block_cmd_o, block_rd_o, in_sr_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hot_i        (hot_i),
        .ref_grant_i  (ref_grant_i),
        .sr_enter_i   (sr_enter_i),
        .sr_exit_i    (sr_exit_i),
        .ref_req_o    (ref_req_o),
        .ref_urgent_o (ref_urgent_o),
        .block_cmd_o  (block_cmd_o),
        .block_rd_o   (block_rd_o),
        .in_sr_o      (in_sr_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        int grants;
        rst_n = 1'b0; hot_i = 1'b0; ref_grant_i = 1'b0;
        sr_enter_i = 1'b0; sr_exit_i = 1'b0;
        wait_n(3);
        check("R1 req in reset", ref_req_o, 0);
        check("R1 urgent in reset", ref_urgent_o, 0);
        check("R1 block_cmd in reset", block_cmd_o, 0);
        check("R1 block_rd in reset", block_rd_o, 0);
        check("R1 in_sr in reset", in_sr_o, 0);
        rst_n = 1'b1;
        wait_n(1);
        check("R1 req after reset", ref_req_o, 0);
        check("R1 block_rd after reset", block_rd_o, 0);

        // R2: first request exactly COOL edges after release.
        wait_n(COOL - 2);
        check("R2 no request one cycle early", ref_req_o, 0);
        wait_n(1);
        check("R2 first request at COOL", ref_req_o, 1);
        check("R5 not urgent with one owed", ref_urgent_o, 0);

        // Table walk of interval lengths under hot flag changes.
        t0 = cyc;
        for (int i = 0; i < NROWS; i++) begin
            hot_i = TBL_HOT[i];
            ref_grant_i = 1'b1;
            @(negedge clk);
            ref_grant_i = 1'b0;
            if (i == 0) begin
                check("R3 block right after grant", block_cmd_o, 1);
                check("R3 request dropped after grant", ref_req_o, 0);
                wait_n(TRFC - 1);
                check("R3 block at last TRFC cycle", block_cmd_o, 1);
                wait_n(1);
                check("R3 block released after TRFC", block_cmd_o, 0);
                check("R8 read block unaffected by refresh", block_rd_o, 0);
            end
            while (!ref_req_o) @(negedge clk);
            check($sformatf("R2 interval row %0d", i), cyc - t0, TBL_GAP[i]);
            t0 = cyc;
        end
        ref_grant_i = 1'b1;
        @(negedge clk);
        ref_grant_i = 1'b0;
        wait_n(TRFC + 2);

        // R3: a grant with nothing owed is ignored.
        hot_i = 1'b1;
        check("R5 idle request low", ref_req_o, 0);
        ref_grant_i = 1'b1;
        @(negedge clk);
        ref_grant_i = 1'b0;
        check("R3 stray grant ignored", block_cmd_o, 0);

        // R4: saturation at eight owed refreshes.
        while (!ref_urgent_o) @(negedge clk);
        check("R5 request with debt", ref_req_o, 1);
        wait_n(2 * HOT);
        check("R4 urgent after extra intervals", ref_urgent_o, 1);
        grants = 0;
        for (int k = 0; k < 20; k++) begin
            while (block_cmd_o) @(negedge clk);
            if (!ref_req_o) break;
            ref_grant_i = 1'b1;
            @(negedge clk);
            ref_grant_i = 1'b0;
            grants++;
            if (grants == 1) check("R4 urgent drops after one grant", ref_urgent_o, 0);
        end
        check("R4 exactly eight grants drain", grants, 8);

        // R6/R7/R8/R9: self-refresh with a refresh owed.
        while (!ref_req_o) @(negedge clk);
        sr_enter_i = 1'b1;
        @(negedge clk);
        sr_enter_i = 1'b0;
        check("R6 entered self-refresh", in_sr_o, 1);
        check("R6 request silenced", ref_req_o, 0);
        check("R6 commands blocked", block_cmd_o, 1);
        check("R6 reads blocked", block_rd_o, 1);
        sr_exit_i = 1'b1;
        @(negedge clk);
        check("R7 exit refused at edge 1", in_sr_o, 1);
        @(negedge clk);
        check("R7 exit refused at edge 2", in_sr_o, 1);
        @(negedge clk);
        check("R7 exit accepted at edge 3", in_sr_o, 0);
        sr_exit_i = 1'b0;
        sr_enter_i = 1'b1;
        @(negedge clk);
        sr_enter_i = 1'b0;
        check("R6 entry refused in exit recovery", in_sr_o, 0);
        wait_n(XSNR - 2);
        check("R8 command block last cycle", block_cmd_o, 1);
        wait_n(1);
        check("R8 command block released", block_cmd_o, 0);
        check("R8 read block still held", block_rd_o, 1);
        wait_n(XSRD - XSNR - 1);
        check("R8 read block last cycle", block_rd_o, 1);
        wait_n(1);
        check("R8 read block released", block_rd_o, 0);
        check("R6 owed count cleared on entry", ref_req_o, 0);
        wait_n(HOT - XSRD - 1);
        check("R9 no request before restarted interval", ref_req_o, 0);
        wait_n(1);
        check("R9 request one hot interval after exit", ref_req_o, 1);
        ref_grant_i = 1'b1;
        @(negedge clk);
        ref_grant_i = 1'b0;
        sr_enter_i = 1'b1;
        @(negedge clk);
        sr_enter_i = 1'b0;
        check("R6 entry refused during refresh recovery", in_sr_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule